// File: doc/BRIEF.md
# Segmented Memory Security Guard

This block stands between a bus and a memory slave. The memory's word address space is cut into equal segments of 2^SEG_SHIFT words. Each segment carries one attribute bit that marks it secure or non-secure. Every incoming read or write is checked against the attribute of the segment it addresses. A permitted request goes straight through to the memory in the same cycle, so the check costs no latency. A request from the non-secure world to a secure segment never reaches the memory, and the block answers it with an error of its own.

A configuration port programs the attribute bits. Only secure writes are accepted on it. Writing a one into the lock register freezes the whole configuration. After that even secure writes are refused, and only a hardware reset opens it again.

Two state machines carry the behaviour. The configuration machine has the states CFG_OPEN and CFG_LOCKED. It starts in CFG_OPEN and takes the transition OPEN_TO_LOCKED when an accepted write sets the lock bit. There is no transition out of CFG_LOCKED except reset. The response machine has the states RSP_IDLE, RSP_READ, RSP_WRITE and RSP_DENY. Each cycle it moves to RSP_READ or RSP_WRITE for a forwarded request, to RSP_DENY for a blocked one, and to RSP_IDLE when there is no request. The state it is in sets the response shown in that cycle.

Top module: `secmem_guard`

## Requirements
- R1: Out of reset, rsp_valid, cfg_ack and mem_req are all low.
- R2: A secure request (req_prot bit 1 = 0) to any segment, secure or non-secure, is forwarded. mem_req rises in the same cycle as req_valid. The response follows one cycle later with rsp_err = 0, and on a read rsp_rdata equals the memory data.
- R3: A non-secure request (req_prot bit 1 = 1) to a segment whose attribute bit is 0 (secure) keeps mem_req low. One cycle later it is answered with rsp_valid = 1, rsp_err = 1 and rsp_rdata = 0.
- R4: A blocked write leaves the memory contents unchanged.
- R5: Configuration index 0 holds the attribute bits: bit k is segment k, 1 = non-secure, 0 = secure. A secure write there is acknowledged one cycle later with cfg_err = 0. It changes which accesses are allowed from the next request on.
- R6: A configuration write with cfg_prot bit 1 = 1 gets cfg_ack = 1 and cfg_err = 1 one cycle later, and it changes no attribute or lock state.
- R7: Writing bit 0 = 1 to configuration index 1 (the lock) moves the block to the locked state. After that every configuration write, even a secure one, is answered with cfg_err = 1 and changes nothing.
- R8: Reset clears the lock and returns every segment to secure.
- R9: Only bit 1 of req_prot decides security. Bits 0 and 2 have no effect on forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_prot | input | 3 | Protection field, bit 1 = non-secure |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | DATA_W | Read data, zero on error or write |
| mem_req | output | 1 | Forwarded request to memory |
| mem_write | output | 1 | Forwarded write enable |
| mem_addr | output | ADDR_W | Forwarded address |
| mem_wdata | output | DATA_W | Forwarded write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after mem_req |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | CFG_IW | Configuration register index |
| cfg_prot | input | 3 | Protection field of the configuration write |
| cfg_wdata | input | DATA_W | Configuration write data |
| cfg_ack | output | 1 | Configuration write answered |
| cfg_err | output | 1 | Configuration write refused |

## Verification
mem_req is combinational. The bench drives a request just after a falling edge and reads mem_req a moment later, in the same cycle. The data response is due in the cycle after the request. It comes from one response state register plus the one-cycle memory model, so the bench samples it at the next falling edge. Configuration answers also come one cycle after the strobe. A new attribute or lock setting takes effect for the first request that follows its acknowledge, so each check of a setting's effect uses a data access issued after that acknowledge.

// File: rtl/secmem_pkg.sv
package secmem_pkg;
    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_READ  = 2'd1,
        RSP_WRITE = 2'd2,
        RSP_DENY  = 2'd3
    } rsp_state_t;

    typedef enum logic {
        CFG_OPEN   = 1'b0,
        CFG_LOCKED = 1'b1
    } cfg_state_t;

    localparam int PROT_NS_BIT = 1;
endpackage

// File: rtl/secmem_seg_lookup.sv
module secmem_seg_lookup #(
    parameter int ADDR_W    = 12,
    parameter int SEG_SHIFT = 8,
    localparam int SEG_IW   = ADDR_W - SEG_SHIFT,
    localparam int NSEG     = 1 << SEG_IW
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NSEG-1:0]   nonsec_map,
    output logic              seg_nonsec
);
    logic [SEG_IW-1:0] seg_idx;

    always_comb begin
        seg_idx    = addr[ADDR_W-1:SEG_SHIFT];
        seg_nonsec = nonsec_map[seg_idx];
    end
endmodule

// File: rtl/secmem_cfg_regs.sv
module secmem_cfg_regs
    import secmem_pkg::*;
#(
    parameter int NSEG   = 16,
    parameter int DATA_W = 32,
    localparam int NWORD  = (NSEG + DATA_W - 1) / DATA_W,
    localparam int CFG_IW = $clog2(NWORD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_IW-1:0] cfg_idx,
    input  logic [2:0]        cfg_prot,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              cfg_ack,
    output logic              cfg_err,
    output logic [NSEG-1:0]   nonsec_map,
    output logic              locked
);
    cfg_state_t state_q, state_d;
    logic       idx_ok;
    logic       wr_ok;
    logic       lock_hit;

    always_comb begin
        idx_ok   = int'(cfg_idx) <= NWORD;
        wr_ok    = cfg_wr && !cfg_prot[PROT_NS_BIT] && idx_ok && (state_q == CFG_OPEN);
        lock_hit = wr_ok && (int'(cfg_idx) == NWORD) && cfg_wdata[0];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_OPEN:   if (lock_hit) state_d = CFG_LOCKED;
            CFG_LOCKED: state_d = CFG_LOCKED;
            default:    state_d = CFG_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_OPEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_ack <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            cfg_ack <= cfg_wr;
            cfg_err <= cfg_wr && !wr_ok;
        end
    end

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        localparam int WIDX = g / DATA_W;
        localparam int BIDX = g % DATA_W;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                nonsec_map[g] <= 1'b0;
            else if (wr_ok && int'(cfg_idx) == WIDX)
                nonsec_map[g] <= cfg_wdata[BIDX];
        end
    end

    assign locked = (state_q == CFG_LOCKED);
endmodule

// File: rtl/secmem_rsp_fsm.sv
module secmem_rsp_fsm
    import secmem_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              allowed,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    rsp_state_t state_q, state_d;

    always_comb begin
        state_d = RSP_IDLE;
        if (req_valid) begin
            if (!allowed)       state_d = RSP_DENY;
            else if (req_write) state_d = RSP_WRITE;
            else                state_d = RSP_READ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            RSP_IDLE:  ;
            RSP_READ:  begin rsp_valid = 1'b1; rsp_rdata = mem_rdata; end
            RSP_WRITE: rsp_valid = 1'b1;
            RSP_DENY:  begin rsp_valid = 1'b1; rsp_err = 1'b1; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/secmem_guard.sv
module secmem_guard
    import secmem_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int SEG_SHIFT = 8,
    localparam int NSEG     = 1 << (ADDR_W - SEG_SHIFT),
    localparam int NWORD    = (NSEG + DATA_W - 1) / DATA_W,
    localparam int CFG_IW   = $clog2(NWORD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_prot,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              cfg_wr,
    input  logic [CFG_IW-1:0] cfg_idx,
    input  logic [2:0]        cfg_prot,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              cfg_ack,
    output logic              cfg_err
);
    logic [NSEG-1:0] nonsec_map;
    logic            locked;
    logic            seg_nonsec;
    logic            allowed;

    secmem_cfg_regs #(.NSEG(NSEG), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_prot(cfg_prot), .cfg_wdata(cfg_wdata),
        .cfg_ack(cfg_ack), .cfg_err(cfg_err),
        .nonsec_map(nonsec_map), .locked(locked)
    );

    secmem_seg_lookup #(.ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT)) u_lookup (
        .addr(req_addr), .nonsec_map(nonsec_map), .seg_nonsec(seg_nonsec)
    );

    always_comb begin
        allowed   = !req_prot[PROT_NS_BIT] || seg_nonsec;
        mem_req   = req_valid && allowed;
        mem_write = req_write;
        mem_addr  = req_addr;
        mem_wdata = req_wdata;
    end

    secmem_rsp_fsm #(.DATA_W(DATA_W)) u_rsp (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .allowed(allowed),
        .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );
endmodule

// File: rtl/secmem_guard_chk.sv
module secmem_guard_chk #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int SEG_SHIFT = 8,
    localparam int NSEG     = 1 << (ADDR_W - SEG_SHIFT)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [2:0]        req_prot,
    input logic              mem_req,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              cfg_wr,
    input logic [2:0]        cfg_prot,
    input logic              cfg_ack,
    input logic              cfg_err,
    input logic [NSEG-1:0]   nonsec_map,
    input logic              locked
);
    // R3
    deny_not_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_prot[1] && !nonsec_map[req_addr[ADDR_W-1:SEG_SHIFT]]) |-> !mem_req);

    // R3
    deny_error_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_prot[1] && !nonsec_map[req_addr[ADDR_W-1:SEG_SHIFT]])
        |=> (rsp_valid && rsp_err && rsp_rdata == '0));

    // R2
    no_spurious_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> req_valid);

    // R6
    ns_cfg_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_prot[1]) |=> (cfg_ack && cfg_err && $stable(nonsec_map)));

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R7
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(nonsec_map));
endmodule

bind secmem_guard secmem_guard_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_SHIFT(SEG_SHIFT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_prot(req_prot), .mem_req(mem_req), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .cfg_wr(cfg_wr),
    .cfg_prot(cfg_prot), .cfg_ack(cfg_ack), .cfg_err(cfg_err),
    .nonsec_map(nonsec_map), .locked(locked)
);

// File: tb/tb_secmem_guard.sv
module tb_secmem_guard;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [2:0]        req_prot = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid, rsp_err;
    logic [DATA_W-1:0] rsp_rdata;
    logic              mem_req, mem_write;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              cfg_wr = 1'b0;
    logic [0:0]        cfg_idx = '0;
    logic [2:0]        cfg_prot = '0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic              cfg_ack, cfg_err;

    int checks = 0;
    int errors = 0;

    logic [DATA_W-1:0] mem_model [logic [ADDR_W-1:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    secmem_guard dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_prot(req_prot), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cfg_wr(cfg_wr),
        .cfg_idx(cfg_idx), .cfg_prot(cfg_prot), .cfg_wdata(cfg_wdata),
        .cfg_ack(cfg_ack), .cfg_err(cfg_err)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_write) mem_model[mem_addr] = mem_wdata;
            else mem_rdata <= mem_model.exists(mem_addr) ? mem_model[mem_addr] : '0;
        end
    end

    task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input logic [2:0] p,
                          input logic [DATA_W-1:0] wd, output bit fwd, output bit err,
                          output logic [DATA_W-1:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_prot = p; req_wdata = wd;
        #1 fwd = mem_req;
        @(negedge clk);
        check("response valid", 32'(rsp_valid), 32'd1);
        err = rsp_err; rd = rsp_rdata;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic cfg_write(input logic [0:0] idx, input logic [2:0] p,
                             input logic [DATA_W-1:0] wd, output bit err);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = idx; cfg_prot = p; cfg_wdata = wd;
        @(negedge clk);
        check("cfg ack", 32'(cfg_ack), 32'd1);
        err = cfg_err;
        cfg_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        check("R1 rsp_valid idle", 32'(rsp_valid), 32'd0);
        check("R1 cfg_ack idle", 32'(cfg_ack), 32'd0);
        check("R1 mem_req idle", 32'(mem_req), 32'd0);
    endtask

    task automatic t_secure_pass();
        bit f, e; logic [DATA_W-1:0] d;
        access(1'b1, 12'h310, 3'b000, 32'hCAFE0001, f, e, d);
        check("R2 secure write forwarded same cycle", 32'(f), 32'd1);
        check("R2 secure write no error", 32'(e), 32'd0);
        access(1'b0, 12'h310, 3'b000, '0, f, e, d);
        check("R2 secure read forwarded", 32'(f), 32'd1);
        check("R2 secure read data", d, 32'hCAFE0001);
    endtask

    task automatic t_ns_blocked();
        bit f, e; logic [DATA_W-1:0] d;
        access(1'b0, 12'h310, 3'b010, '0, f, e, d);
        check("R3 ns read not forwarded", 32'(f), 32'd0);
        check("R3 ns read error", 32'(e), 32'd1);
        check("R3 ns read zero data", d, 32'd0);
        access(1'b1, 12'h310, 3'b010, 32'hBAD0BAD0, f, e, d);
        check("R3 ns write not forwarded", 32'(f), 32'd0);
        access(1'b0, 12'h310, 3'b000, '0, f, e, d);
        check("R4 memory unchanged after blocked write", d, 32'hCAFE0001);
    endtask

    task automatic t_prot_bits();
        bit f, e; logic [DATA_W-1:0] d;
        access(1'b0, 12'h310, 3'b101, '0, f, e, d);
        check("R9 prot bits 0 and 2 ignored, forwarded", 32'(f), 32'd1);
        check("R9 prot bits 0 and 2 ignored, no error", 32'(e), 32'd0);
    endtask

    task automatic t_cfg_open();
        bit f, e; logic [DATA_W-1:0] d;
        cfg_write(1'b0, 3'b000, 32'h0000_0008, e);
        check("R5 secure cfg write accepted", 32'(e), 32'd0);
        access(1'b1, 12'h320, 3'b010, 32'h1234ABCD, f, e, d);
        check("R5 ns write to ns segment forwarded", 32'(f), 32'd1);
        access(1'b0, 12'h320, 3'b000, '0, f, e, d);
        check("R2 secure read of ns segment", d, 32'h1234ABCD);
        access(1'b0, 12'h510, 3'b010, '0, f, e, d);
        check("R5 other segment still secure", 32'(e), 32'd1);
    endtask

    task automatic t_cfg_ns_refused();
        bit f, e; logic [DATA_W-1:0] d;
        cfg_write(1'b0, 3'b010, 32'h0000_0020, e);
        check("R6 ns cfg write error", 32'(e), 32'd1);
        access(1'b0, 12'h510, 3'b010, '0, f, e, d);
        check("R6 segment 5 unchanged (still secure)", 32'(f), 32'd0);
        access(1'b0, 12'h320, 3'b010, '0, f, e, d);
        check("R6 segment 3 unchanged (still ns)", 32'(f), 32'd1);
    endtask

    task automatic t_lock();
        bit f, e; logic [DATA_W-1:0] d;
        cfg_write(1'b1, 3'b000, 32'h1, e);
        check("R7 lock write accepted", 32'(e), 32'd0);
        cfg_write(1'b0, 3'b000, 32'h0000_0020, e);
        check("R7 secure cfg write refused after lock", 32'(e), 32'd1);
        access(1'b0, 12'h510, 3'b010, '0, f, e, d);
        check("R7 segment 5 still secure after lock", 32'(f), 32'd0);
        access(1'b0, 12'h320, 3'b010, '0, f, e, d);
        check("R7 segment 3 still ns after lock", 32'(f), 32'd1);
    endtask

    task automatic t_reset_clears();
        bit f, e; logic [DATA_W-1:0] d;
        do_reset();
        access(1'b0, 12'h320, 3'b010, '0, f, e, d);
        check("R8 segment 3 secure again after reset", 32'(e), 32'd1);
        cfg_write(1'b0, 3'b000, 32'h0000_0020, e);
        check("R8 cfg write accepted after reset (unlocked)", 32'(e), 32'd0);
        access(1'b0, 12'h510, 3'b010, '0, f, e, d);
        check("R8 new map applies after reset", 32'(f), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_secure_pass();
        t_ns_blocked();
        t_prot_bits();
        t_cfg_open();
        t_cfg_ns_refused();
        t_lock();
        t_reset_clears();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule